// File: doc/BRIEF.md
# Codec register initialization sequencer

This block brings a group of attached audio codecs into a known state after power-up. It walks a fixed, read-only table of register address and data pairs and hands each pair, as one write, to an external serial control-port master over a valid/ready handshake. The table ends at an entry whose address byte is 0xFF, and that entry is never written. The whole table is replayed once for every attached codec, and each write carries the index of the chip it targets.

A two-bit type input picks the table and, with it, how many chips are present. After each accepted write the block waits a fixed settling time, counted in clock cycles, before it presents the next one. A start pulse launches a run. `busy` is high while a run is in progress, and `done` pulses for one cycle when the run is over. The control-port master, power sequencing and any readback are outside this block.

Top module: `codec_init_seq`

## Requirements
- R1: After reset, `wr_valid`, `busy` and `done` are low.
- R2: Type code 0 writes the pairs (0x01,0x00), (0x02,0x5A), (0x04,0x11), (0x01,0x03). Type code 1 writes (0x10,0xC1), (0x12,0x00), (0x13,0x7F), (0x10,0xC0), (0x14,0x08). Type code 2 writes (0x03,0x44), (0x05,0x0F). Pairs are written strictly in that order, and a repeated address is written again each time it appears.
- R3: A table entry whose address byte is 0xFF ends the table and produces no write, so `wr_addr` is never 0xFF while `wr_valid` is high.
- R4: The full table is replayed from its first entry for chip indices 0 up to N-1. N is `dac_count`/2 (rounded down) for type codes 0 and 2, and N is 1 for type code 1. `wr_chip` carries the current index.
- R5: After each accepted write (`wr_valid` and `wr_ready` both high at a clock edge), `wr_valid` stays low for at least DELAY_CYCLES cycles.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_chip`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R7: Type code 3 has no table, and a chip count of zero has nothing to write. In either case a start issues no writes and `done` pulses in the cycle after the start.
- R8: A start pulse that arrives while `busy` is high is ignored. The run in progress keeps its type and chip count.
- R9: `done` is a one-cycle pulse. It is raised after the delay of the last write has expired, with `busy` already low. `busy` stays high from the cycle after an accepted start until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| codec_type | input | 2 | Table select, sampled at start |
| dac_count | input | DAC_W | Number of DAC channels, sampled at start |
| wr_ready | input | 1 | Control-port master accepts the write |
| wr_valid | output | 1 | A write is presented |
| wr_chip | output | DAC_W-1 | Target chip index |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each table is run against several chip counts, and random `dac_count` values are included. This shows whether the replay restarts at the first entry for every chip and stops at the correct last index. The ready input is sometimes always high and sometimes stalls at random, which separates correct holding and ordering from a design that only works when writes are accepted at once. Directed cases cover the type without a table, a zero chip count, and a start injected during a run. They show whether the block gives an immediate done and whether it ignores a second request.

// File: rtl/codec_init_pkg.sv
// Shared types for the codec initialization sequencer.
// Assumes register addresses and data are one byte each.
package codec_init_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CHECK,
        SEQ_SEND,
        SEQ_SETTLE
    } seq_state_t;

    typedef enum logic [1:0] {
        CT_DUAL_A  = 2'd0,
        CT_SINGLE  = 2'd1,
        CT_DUAL_B  = 2'd2,
        CT_NOTABLE = 2'd3
    } codec_kind_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_pair_t;

    localparam logic [7:0] END_MARK = 8'hFF;

endpackage

// File: rtl/codec_init_rom.sv
// Read-only pair tables, one per codec kind, selected combinationally.
// Assumes every table ends with an END_MARK entry. Indices past the
// end read back as END_MARK.
module codec_init_rom
    import codec_init_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [1:0]       sel,
    input  logic [IDX_W-1:0] idx,
    output reg_pair_t        pair,
    output logic             has_table,
    output logic             per_dac
);

    // Decode the pair at (sel, idx) and the chip-count rule for sel.
    always_comb begin
        pair      = '{addr: END_MARK, data: 8'h00};
        has_table = 1'b1;
        per_dac   = 1'b0;
        unique case (codec_kind_t'(sel))
            CT_DUAL_A: begin
                per_dac = 1'b1;
                case (idx)
                    0: pair = '{addr: 8'h01, data: 8'h00};
                    1: pair = '{addr: 8'h02, data: 8'h5A};
                    2: pair = '{addr: 8'h04, data: 8'h11};
                    3: pair = '{addr: 8'h01, data: 8'h03};
                    default: ;
                endcase
            end
            CT_SINGLE: begin
                case (idx)
                    0: pair = '{addr: 8'h10, data: 8'hC1};
                    1: pair = '{addr: 8'h12, data: 8'h00};
                    2: pair = '{addr: 8'h13, data: 8'h7F};
                    3: pair = '{addr: 8'h10, data: 8'hC0};
                    4: pair = '{addr: 8'h14, data: 8'h08};
                    default: ;
                endcase
            end
            CT_DUAL_B: begin
                per_dac = 1'b1;
                case (idx)
                    0: pair = '{addr: 8'h03, data: 8'h44};
                    1: pair = '{addr: 8'h05, data: 8'h0F};
                    default: ;
                endcase
            end
            default: has_table = 1'b0;
        endcase
    end

endmodule

// File: rtl/codec_init_timer.sv
// Down-counter for the settling delay after each write.
// A load starts a window of CYCLES ticks. expired is high once the
// count has reached zero. Assumes CYCLES >= 1.
module codec_init_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);

    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load to CYCLES-1 and count down while ticking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/codec_init_seq.sv
// Codec register initialization sequencer (top).
// Replays the selected pair table once per chip. Each pair is one
// valid/ready write, and a DELAY_CYCLES settling gap follows every
// accepted write. Inputs codec_type and dac_count are sampled at start.
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int DELAY_CYCLES = 1000,
    parameter int DAC_W        = 4,
    parameter int IDX_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       codec_type,
    input  logic [DAC_W-1:0] dac_count,
    input  logic             wr_ready,
    output logic             wr_valid,
    output logic [DAC_W-2:0] wr_chip,
    output logic [7:0]       wr_addr,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done
);

    localparam int CHIP_W = DAC_W - 1;

    seq_state_t        state_q;
    logic [1:0]        type_q;
    logic [CHIP_W-1:0] chips_q;
    logic [CHIP_W-1:0] chip_q;
    logic [IDX_W-1:0]  idx_q;
    reg_pair_t         pair;
    logic              has_table;
    logic              per_dac;
    logic              settled;
    logic [1:0]        rom_sel;
    logic [CHIP_W-1:0] chips_new;

    // While idle the ROM looks at the live type, otherwise at the latched one.
    assign rom_sel = (state_q == SEQ_IDLE) ? codec_type : type_q;

    codec_init_rom #(.IDX_W(IDX_W)) rom_i (
        .sel       (rom_sel),
        .idx       (idx_q),
        .pair      (pair),
        .has_table (has_table),
        .per_dac   (per_dac)
    );

    codec_init_timer #(.CYCLES(DELAY_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == SEQ_SEND && wr_ready),
        .tick    (state_q == SEQ_SETTLE),
        .expired (settled)
    );

    // Chip count for a start request: half the DAC count, or one.
    assign chips_new = per_dac ? dac_count[DAC_W-1:1] : CHIP_W'(1);

    // Main sequencing: check entry, present write, settle, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            type_q   <= '0;
            chips_q  <= '0;
            chip_q   <= '0;
            idx_q    <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        type_q  <= codec_type;
                        chips_q <= chips_new;
                        chip_q  <= '0;
                        idx_q   <= '0;
                        if (!has_table || chips_new == '0) begin
                            done <= 1'b1;
                        end else begin
                            state_q <= SEQ_CHECK;
                        end
                    end
                end
                SEQ_CHECK: begin
                    if (pair.addr == END_MARK) begin
                        idx_q <= '0;
                        if (chip_q == chips_q - 1'b1) begin
                            done    <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end else begin
                            chip_q <= chip_q + 1'b1;
                        end
                    end else begin
                        wr_addr  <= pair.addr;
                        wr_data  <= pair.data;
                        wr_valid <= 1'b1;
                        state_q  <= SEQ_SEND;
                    end
                end
                SEQ_SEND: begin
                    if (wr_ready) begin
                        wr_valid <= 1'b0;
                        state_q  <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (settled) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SEQ_CHECK;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign wr_chip = chip_q;
    assign busy    = (state_q != SEQ_IDLE);

endmodule

// File: rtl/codec_init_seq_chk.sv
// Protocol checker for codec_init_seq, bound to every instance.
// Assumes the same DELAY_CYCLES as the instance it watches.
module codec_init_seq_chk #(
    parameter int DELAY_CYCLES = 1000,
    parameter int DAC_W        = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ready,
    input logic             wr_valid,
    input logic [DAC_W-2:0] wr_chip,
    input logic [7:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             busy,
    input logic             done
);

    logic [31:0] gap_q;
    logic        seen_q;

    // Count idle cycles since the last accepted write within a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (wr_valid && wr_ready) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            if (!wr_valid && gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 1;
            if (done) seen_q <= 1'b0;
        end
    end

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)
                                     && $stable(wr_data) && $stable(wr_chip)));

    a_r3_no_end_mark: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr != 8'hFF));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_valid));

    a_r5_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !$past(wr_valid) && seen_q) |-> (gap_q >= DELAY_CYCLES));

    a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);

endmodule

bind codec_init_seq codec_init_seq_chk #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .DAC_W        (DAC_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_chip  (wr_chip),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .done     (done)
);

// File: tb/codec_init_seq_tb_top.sv
module codec_init_seq_tb_top;

    localparam int D     = 5;
    localparam int DAC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       codec_type = '0;
    logic [DAC_W-1:0] dac_count = '0;
    logic             wr_ready = 1'b0;
    logic             wr_valid;
    logic [DAC_W-2:0] wr_chip;
    logic [7:0]       wr_addr;
    logic [7:0]       wr_data;
    logic             busy;
    logic             done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    codec_init_seq #(.DELAY_CYCLES(D), .DAC_W(DAC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .codec_type(codec_type),
        .dac_count(dac_count), .wr_ready(wr_ready), .wr_valid(wr_valid),
        .wr_chip(wr_chip), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    function automatic int exp_len(int t);
        case (t)
            0: return 4;
            1: return 5;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_pair(int t, int i);
        logic [15:0] a0 [4] = '{16'h0100, 16'h025A, 16'h0411, 16'h0103};
        logic [15:0] a1 [5] = '{16'h10C1, 16'h1200, 16'h137F, 16'h10C0, 16'h1408};
        logic [15:0] a2 [2] = '{16'h0344, 16'h050F};
        case (t)
            0: return a0[i];
            1: return a1[i];
            default: return a2[i];
        endcase
    endfunction

    function automatic int exp_chips(int t, int dac);
        if (t == 1) return 1;
        if (t == 3) return 0;
        return dac / 2;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One run: start, drive ready, record writes, compare with the model.
    task automatic run(int t, int dac, int stall_pct, bit inject);
        logic [DAC_W-2:0] gc [64];
        logic [15:0]      gp [64];
        int  n = 0, gap = 0, tmo = 0, got_done = 0, done_cyc = 0;
        bit  seen_hs = 0, prev_stall = 0, prev_valid = 0, busy_bad = 0;
        bit  gap_bad = 0, hold_bad = 0, mark_bad = 0;
        logic [15:0] prev_p = '0;
        int  nc = exp_chips(t, dac), nl = exp_len(t), bad_at = -1;
        @(negedge clk);
        codec_type = 2'(t);
        dac_count  = DAC_W'(dac);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        while (tmo < 5000) begin
            if (done) begin got_done = 1; done_cyc = tmo; break; end
            if (!busy) busy_bad = 1;
            @(negedge clk);
            tmo++;
            wr_ready = ($urandom_range(99) >= stall_pct);
            if (inject && tmo == 3) begin
                start = 1'b1; codec_type = 2'((t + 1) % 3); dac_count = DAC_W'(14);
            end else begin
                start = 1'b0;
            end
            #1;
            if (prev_stall && (!wr_valid || {wr_addr, wr_data} != prev_p)) hold_bad = 1;
            if (wr_valid && !prev_valid && seen_hs && gap < D) gap_bad = 1;
            if (wr_valid && wr_addr == 8'hFF) mark_bad = 1;
            if (wr_valid && wr_ready) begin
                if (n < 64) begin gc[n] = wr_chip; gp[n] = {wr_addr, wr_data}; end
                n++; seen_hs = 1; gap = 0;
            end else if (!wr_valid) begin
                gap++;
            end
            prev_stall = wr_valid && !wr_ready;
            prev_valid = wr_valid;
            prev_p     = {wr_addr, wr_data};
        end
        start = 1'b0;
        check(got_done == 1, "R9 done seen", got_done, 1);
        check(n == nc * nl, "R4 write count", n, nc * nl);
        for (int k = 0; k < n && k < 64 && k < nc * nl; k++) begin
            if (gc[k] != (DAC_W-1)'(k / nl) || gp[k] != exp_pair(t, k % nl)) begin
                bad_at = k; break;
            end
        end
        check(bad_at < 0, "R2 order/content", bad_at, -1);
        check(!gap_bad, "R5 settle gap", gap_bad, 0);
        check(!hold_bad, "R6 hold stable", hold_bad, 0);
        check(!mark_bad, "R3 end mark written", mark_bad, 0);
        if (nc == 0 || nl == 0)
            check(done_cyc == 0, "R7 immediate done", done_cyc, 0);
        else
            check(!busy_bad, "R9 busy during run", busy_bad, 0);
        check(!busy, "R9 busy low at done", busy, 0);
        @(negedge clk);
        #1;
        check(!done && !busy, "R9 done one cycle", done, 0);
        if (inject) check(n == nc * nl, "R8 start ignored while busy", n, nc * nl);
        wr_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(!wr_valid && !busy && !done, "R1 reset state", {wr_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!wr_valid && !busy && !done, "R1 idle after reset", {wr_valid, busy, done}, 0);
        run(0, 4, 0, 0);    // R2 R4: two chips, no stall
        run(1, 0, 30, 0);   // R4: single chip regardless of dac_count
        run(2, 6, 50, 0);   // R4: three chips with stalls
        run(3, 8, 0, 0);    // R7: no table
        run(0, 1, 0, 0);    // R7: zero chips
        run(2, 4, 20, 1);   // R8: injected start
        run(0, 14, 40, 0);  // R4: seven chips
        for (int r = 0; r < 8; r++)
            run(int'($urandom_range(3)), int'($urandom_range(15)),
                int'($urandom_range(70)), bit'($urandom_range(1)));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule